// File: doc/BRIEF.md
# Hit-Pattern Gated Waveform Readout

This block sits behind a sixteen-channel digitizer and decides which channels are read out when a trigger arrives. Every channel writes its 12-bit samples into its own circular history buffer on every clock. A trigger comes with a 64-bit hit pattern built upstream by a cluster finder. This module uses one 16-bit quarter of that pattern, chosen by a slot index. Only the channels whose bit is set in that quarter are read out, and the rest are dropped. This keeps the event size small when background spreads energy over many channels.

For each accepted trigger, the block freezes a ten-sample window per channel. The window begins a programmable number of samples before the trigger sample. The block then streams one word per clock: an event header carrying a running event number, then a channel header and ten samples for each selected channel in ascending channel order, and finally a trailer that carries the number of channels read. There is no handshake on the output. Triggers that arrive while an event is being processed are dropped.

Top module: `pws_readout`

## Requirements
- R1: After reset, `busy` and `out_valid` are low, and the first accepted event carries event number 0.
- R2: The channel selection is `trig_pattern[slot_sel*16 +: 16]`, with bit c selecting channel c. The other three quarters of the pattern have no effect on the output.
- R3: Each selected channel appears exactly once, in ascending channel order, as a channel header followed by exactly 10 sample words. No unselected channel appears.
- R4: Sample word k (k = 0..9) of a channel holds the value that was on that channel's input at the clock edge lying `pre_cnt - k` edges before the trigger edge. A negative distance means after the trigger edge. With `pre_cnt` = 0, the first sample is the one taken at the trigger edge.
- R5: A `pre_cnt` above 64 behaves exactly like 64.
- R6: Word encoding uses bits [15:14] as the tag. Tag 11 is the event header, with the event number in [13:0]. Tag 10 is the channel header, with the channel number in [3:0] and zeros above. Tag 00 is a sample, with the value in [11:0] and zeros above. Tag 01 is the trailer, with the count of selected channels in [4:0] and zeros above.
- R7: An event with no channel selected produces an event header followed directly by a trailer with count 0.
- R8: `busy` rises on the edge after an accepted trigger and falls in the cycle in which the trailer is on the output. A trigger seen while `busy` is high is ignored and not counted. The event number rises by one per accepted trigger.
- R9: From the event header to the trailer, `out_valid` is high on every cycle. Outside an event, `out_valid` is high only for the trailer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_smp | input | 192 | Current sample of each channel, channel c in bits [c*12 +: 12] |
| trig | input | 1 | Trigger request, taken when `busy` is low |
| trig_pattern | input | 64 | Hit pattern from the cluster finder |
| slot_sel | input | 2 | Picks the 16-bit quarter of the pattern that belongs to this module |
| pre_cnt | input | 7 | Number of samples the window starts before the trigger sample |
| busy | output | 1 | An accepted event is still in progress |
| out_valid | output | 1 | `out_word` holds a word of the event stream |
| out_word | output | 16 | Tagged event stream word |

## Verification
The close of one event and the acceptance of the next can happen in the same cycle. `busy` drops while the trailer is on the output, and a trigger held high at that moment must start a new event at once.

The bench provokes this case by keeping the trigger asserted across a whole event. It records the cycle in which `busy` is seen low next to the trailer. It then checks that the second stream carries the next event number and a window anchored on exactly that cycle, with no event counted for the trigger cycles in between.

// File: rtl/pws_pkg.sv
package pws_pkg;
   // tag in the two top bits of each stream word
   localparam logic [1:0] TAG_SMP = 2'b00;
   localparam logic [1:0] TAG_TRL = 2'b01;
   localparam logic [1:0] TAG_CHD = 2'b10;
   localparam logic [1:0] TAG_EVH = 2'b11;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_CAPT,
      ST_EVH,
      ST_CHD,
      ST_SMP,
      ST_TRL
   } pws_state_t;
endpackage

// File: rtl/pws_ring.sv
// Per-channel circular sample history, written every cycle.
module pws_ring #(
   parameter int SW    = 12,
   parameter int DEPTH = 128,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic [SW-1:0] wr_data,
   input  logic [AW-1:0] wr_addr,
   input  logic [AW-1:0] rd_addr,
   output logic [SW-1:0] rd_data
);
   logic [SW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pws_first_set.sv
// Index of the lowest set bit of a request vector.
module pws_first_set #(
   parameter int N   = 16,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/pws_readout.sv
module pws_readout #(
   parameter int NCH     = 16,
   parameter int SW      = 12,
   parameter int WIN     = 10,
   parameter int MAX_PRE = 64,
   parameter int DEPTH   = 128,
   parameter int PAT_W   = 64,
   localparam int SLOTS  = PAT_W / NCH,
   localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int PRE_W  = $clog2(MAX_PRE + 1),
   localparam int OW     = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NCH*SW-1:0]   adc_smp,
   input  logic                trig,
   input  logic [PAT_W-1:0]    trig_pattern,
   input  logic [SLOT_W-1:0]   slot_sel,
   input  logic [PRE_W-1:0]    pre_cnt,
   output logic                busy,
   output logic                out_valid,
   output logic [OW-1:0]       out_word
);
   import pws_pkg::*;

   localparam int AW    = $clog2(DEPTH);
   localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int CNT_W = (WIN > 1) ? $clog2(WIN) : 1;
   localparam int NS_W  = $clog2(NCH + 1);
   localparam int PL_W  = OW - 2;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIN - 1);

   // elaboration-time parameter checks
   if (PAT_W % NCH != 0) begin : g_bad_pat
      $error("PAT_W must be a multiple of NCH");
   end
   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end
   if (DEPTH <= MAX_PRE + WIN + 1) begin : g_bad_hist
      $error("DEPTH too small for MAX_PRE plus window");
   end
   if (SW > PL_W || CH_W > PL_W || NS_W > PL_W) begin : g_bad_word
      $error("fields do not fit the word payload");
   end

   pws_state_t          state;
   logic [AW-1:0]       wp, base, rd_addr;
   logic [CNT_W-1:0]    cnt;
   logic [NCH-1:0]      mask, sel;
   logic [CH_W-1:0]     cur, first_idx;
   logic [NS_W-1:0]     nsel;
   logic [PL_W-1:0]     evn;
   logic [PRE_W-1:0]    pre_eff;
   logic [SW-1:0]       rd_data [NCH];
   logic [SW-1:0]       cap [NCH][WIN];

   // pick this module's share of the pattern
   if (SLOTS > 1) begin : g_slot_mux
      assign sel = trig_pattern[slot_sel*NCH +: NCH];
   end else begin : g_slot_fixed
      logic unused_slot;
      assign unused_slot = ^slot_sel;
      assign sel = trig_pattern[NCH-1:0];
   end

   assign pre_eff = (pre_cnt > PRE_W'(MAX_PRE)) ? PRE_W'(MAX_PRE) : pre_cnt;
   assign rd_addr = base + AW'(cnt);
   assign busy    = (state != ST_IDLE);

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      pws_ring #(.SW(SW), .DEPTH(DEPTH)) u_ring (
         .clk     (clk),
         .wr_data (adc_smp[c*SW +: SW]),
         .wr_addr (wp),
         .rd_addr (rd_addr),
         .rd_data (rd_data[c])
      );
   end

   pws_first_set #(.N(NCH)) u_first (
      .req (mask),
      .idx (first_idx)
   );

   // window freeze: one sample index per cycle, all channels in parallel
   always_ff @(posedge clk) begin
      if (state == ST_CAPT) begin
         for (int c = 0; c < NCH; c++) cap[c][cnt] <= rd_data[c];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         wp        <= '0;
         base      <= '0;
         cnt       <= '0;
         mask      <= '0;
         cur       <= '0;
         nsel      <= '0;
         evn       <= '0;
         out_valid <= 1'b0;
         out_word  <= '0;
      end else begin
         wp        <= wp + AW'(1);
         out_valid <= 1'b0;
         case (state)
            ST_IDLE: if (trig) begin
               mask  <= sel;
               base  <= wp - AW'(pre_eff);
               cnt   <= '0;
               nsel  <= '0;
               state <= ST_WAIT;
            end
            ST_WAIT: begin
               // let the samples after the trigger land in the history
               if (cnt == CNT_LAST) begin
                  cnt   <= '0;
                  state <= ST_CAPT;
               end else cnt <= cnt + CNT_W'(1);
            end
            ST_CAPT: begin
               if (cnt == CNT_LAST) begin
                  cnt   <= '0;
                  state <= ST_EVH;
               end else cnt <= cnt + CNT_W'(1);
            end
            ST_EVH: begin
               out_valid <= 1'b1;
               out_word  <= {TAG_EVH, evn};
               cur       <= first_idx;
               state     <= (mask != '0) ? ST_CHD : ST_TRL;
            end
            ST_CHD: begin
               out_valid <= 1'b1;
               out_word  <= {TAG_CHD, PL_W'(cur)};
               mask      <= mask & ~(NCH'(1) << cur);
               nsel      <= nsel + NS_W'(1);
               cnt       <= '0;
               state     <= ST_SMP;
            end
            ST_SMP: begin
               out_valid <= 1'b1;
               out_word  <= {TAG_SMP, PL_W'(cap[cur][cnt])};
               if (cnt == CNT_LAST) begin
                  cnt <= '0;
                  if (mask != '0) begin
                     cur   <= first_idx;
                     state <= ST_CHD;
                  end else state <= ST_TRL;
               end else cnt <= cnt + CNT_W'(1);
            end
            ST_TRL: begin
               out_valid <= 1'b1;
               out_word  <= {TAG_TRL, PL_W'(nsel)};
               evn       <= evn + PL_W'(1);
               state     <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pws_readout_chk.sv
module pws_readout_chk #(
   parameter int OW  = 16,
   parameter int SW  = 12,
   parameter int NCH = 16,
   localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          trig,
   input logic          busy,
   input logic          out_valid,
   input logic [OW-1:0] out_word
);
   import pws_pkg::*;

   logic [1:0]      tag;
   logic [CH_W-1:0] ch, last_ch;
   logic            seen;

   assign tag = out_word[OW-1 -: 2];
   assign ch  = out_word[CH_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen    <= 1'b0;
         last_ch <= '0;
      end else if (out_valid && tag == TAG_EVH) begin
         seen <= 1'b0;
      end else if (out_valid && tag == TAG_CHD) begin
         seen    <= 1'b1;
         last_ch <= ch;
      end
   end

   assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && trig) |=> busy);

   assert_trailer_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && tag == TAG_TRL) |-> !busy);

   assert_stream_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && tag != TAG_TRL) |-> busy);

   assert_contiguous_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && tag != TAG_TRL) |=> out_valid);

   assert_after_header_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && tag == TAG_EVH) |=> (out_valid && (tag == TAG_CHD || tag == TAG_TRL)));

   assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && tag == TAG_CHD && seen) |-> (ch > last_ch));

   assert_sample_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && tag == TAG_SMP) |-> (out_word[OW-3:SW] == '0));
endmodule

bind pws_readout pws_readout_chk #(.OW(OW), .SW(SW), .NCH(NCH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .trig      (trig),
   .busy      (busy),
   .out_valid (out_valid),
   .out_word  (out_word)
);

// File: tb/sim_pws_readout.sv
`timescale 1ns/1ps
module sim_pws_readout;
   localparam int NCH = 16, SW = 12, WIN = 10, OW = 16;

   logic              clk = 1'b0, rst_n = 1'b0, trig = 1'b0;
   logic [NCH*SW-1:0] adc = '0;
   logic [63:0]       pat = '0;
   logic [1:0]        slot = '0;
   logic [6:0]        pre = '0;
   logic              busy, out_valid;
   logic [OW-1:0]     out_word;

   pws_readout u0 (
      .clk(clk), .rst_n(rst_n), .adc_smp(adc), .trig(trig),
      .trig_pattern(pat), .slot_sel(slot), .pre_cnt(pre),
      .busy(busy), .out_valid(out_valid), .out_word(out_word)
   );

   always #2.5 clk = ~clk;

   int cyc = 0, nchk = 0, nerr = 0, ngot = 0, nexp = 0, exp_evn = 0;
   logic [15:0] got [0:255];
   logic [15:0] exp_w [0:255];
   bit open_prev = 1'b0;

   function automatic logic [11:0] smp_val(int ch, int n);
      return 12'((n * 37 + ch * 211) % 4096);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int ex);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual %0h expected %0h", req, act, ex);
      end
   endtask

   // sample driver and stream collector, both away from the active edge
   always @(negedge clk) begin
      cyc = cyc + 1;
      for (int c = 0; c < NCH; c++) adc[c*SW +: SW] = smp_val(c, cyc);
      if (open_prev) chk(out_valid, "R9 gap inside event", int'(out_valid), 1);
      if (out_valid) begin
         if (out_word[15:14] == 2'b01)
            chk(!busy, "R8 busy low with trailer", int'(busy), 0);
         else
            chk(busy, "R8 busy high during event", int'(busy), 1);
         if (ngot < 256) begin
            got[ngot] = out_word;
            ngot = ngot + 1;
         end
      end
      open_prev = out_valid && (out_word[15:14] != 2'b01);
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         nchk++; nerr++;
         $display("FAIL watchdog actual %0d expected below 150000", cyc);
         $display("CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end

   task automatic build(input logic [63:0] p, input logic [1:0] s, input int pr, input int n0);
      logic [15:0] sl;
      int pe, cntc;
      sl = p[s*16 +: 16];
      pe = (pr > 64) ? 64 : pr;
      nexp = 0; cntc = 0;
      exp_w[nexp] = {2'b11, 14'(exp_evn)}; nexp++;
      for (int ch = 0; ch < NCH; ch++) begin
         if (sl[ch]) begin
            exp_w[nexp] = {2'b10, 14'(ch)}; nexp++;
            for (int k = 0; k < WIN; k++) begin
               exp_w[nexp] = {4'b0000, smp_val(ch, n0 - pe + k)}; nexp++;
            end
            cntc++;
         end
      end
      exp_w[nexp] = {2'b01, 14'(cntc)}; nexp++;
   endtask

   task automatic compare(input string what);
      chk(ngot == nexp, {"R3 word count ", what}, ngot, nexp);
      for (int i = 0; i < nexp && i < ngot; i++) begin
         case (exp_w[i][15:14])
            2'b11:   chk(got[i] == exp_w[i], {"R8 event header ", what}, got[i], exp_w[i]);
            2'b10:   chk(got[i] == exp_w[i], {"R3 channel header ", what}, got[i], exp_w[i]);
            2'b00:   chk(got[i] == exp_w[i], {"R4 sample ", what}, got[i], exp_w[i]);
            default: chk(got[i] == exp_w[i], {"R6 trailer ", what}, got[i], exp_w[i]);
         endcase
      end
      exp_evn++;
   endtask

   task automatic wait_trailer();
      do begin @(negedge clk); #1; end
      while (ngot == 0 || got[ngot-1][15:14] != 2'b01);
   endtask

   task automatic run(input logic [63:0] p, input logic [1:0] s, input int pr, input string what);
      int n0;
      do begin @(negedge clk); #1; end while (busy);
      ngot = 0;
      pat = p; slot = s; pre = 7'(pr); trig = 1'b1;
      n0 = cyc;
      @(negedge clk); #1;
      trig = 1'b0;
      pat = {$urandom, $urandom}; slot = 2'($urandom); pre = 7'($urandom);
      wait_trailer();
      build(p, s, pr, n0);
      compare(what);
   endtask

   initial begin
      int n0, n1;
      logic [63:0] p;
      void'($urandom(1234));
      repeat (3) @(negedge clk);
      #1;
      chk(!busy, "R1 busy after reset", int'(busy), 0);
      chk(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
      rst_n = 1'b1;
      repeat (100) @(negedge clk);
      #1;
      chk(!busy && !out_valid, "R1 idle before first trigger", int'(busy), 0);

      run(64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 0, "R1 first event all channels pre 0");
      run(64'h0000_0000_0000_0000, 2'd0, 20, "R7 empty selection");
      run(64'hFFFF_8001_FFFF_FFFF, 2'd2, 5, "R2 slot 2 picks two channels");
      run(64'hFFFF_FFFF_0000_FFFF, 2'd1, 9, "R2 zero quarter gives empty event");
      run(64'h0421_0000_0000_0000, 2'd3, 100, "R5 pre above 64 clamps");
      run(64'h0000_0000_8000_0000, 2'd1, 64, "R4 pre at 64 channel 15");

      for (int e = 0; e < 12; e++) begin
         p = {$urandom, $urandom};
         if (e % 3 == 1) p = p & {$urandom, $urandom} & {$urandom, $urandom};
         run(p, 2'($urandom), int'($urandom % 65), "R3 random event");
      end

      // trigger held across a whole event: re-armed in the trailer cycle
      do begin @(negedge clk); #1; end while (busy);
      ngot = 0;
      p = 64'h0000_3C00_0000_0000;
      pat = p; slot = 2'd2; pre = 7'd12; trig = 1'b1;
      n0 = cyc;
      do begin @(negedge clk); #1; end while (busy);
      chk(ngot > 0 && got[ngot-1][15:14] == 2'b01, "R8 busy falls with trailer",
          (ngot > 0) ? int'(got[ngot-1][15:14]) : -1, 1);
      n1 = cyc;
      build(p, 2'd2, 12, n0);
      compare("R8 held trigger first event");
      ngot = 0;
      @(negedge clk); #1;
      chk(busy, "R8 held trigger re-accepted at trailer", int'(busy), 1);
      trig = 1'b0;
      wait_trailer();
      build(p, 2'd2, 12, n1);
      compare("R8 held trigger second event");

      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule